// File: doc/BRIEF.md
# Fast Command Broadcast Transmitter

This block sends 16-bit fast command words to a group of front-end boards. A command comes from one of two sources: the timing-controller side or the host register side. The block serializes the word on an asynchronous single-wire link. Each frame is one start bit, sixteen data bits with no parity, and two stop bits. The frame goes out in exact lockstep on every output lane whose bit in a software-written enable mask is set. Lanes that are not enabled stay at the idle level.

The block runs from the 40 MHz system clock. The width of one bit is a programmable count of clock cycles. A request that finds the transmitter free starts its frame after one fixed cycle of latency, which is what the synchronization command needs. A request that arrives while a frame is on the wire is held in a single-entry buffer and follows directly after the current frame. The block also reports which kind of command each frame carries, so that acquisition start, acquisition stop, clock-alignment and buffer-reset commands can be seen at launch.

Top module: `fast_cmd_broadcast`

## Requirements
- R1: A frame is a low start bit, then the 16 command bits least significant bit first, then two high stop bits. Each bit lasts `bit_period_i` clock cycles, and a value of 0 is treated as 1.
- R2: Bit i of `port_mask_i` enables lane `port_line_o[i]`. Every enabled lane carries the identical waveform in the same cycles, and every disabled lane stays high for the whole frame.
- R3: The mask and the bit period are captured in the cycle a frame is launched. Changes to them during that frame do not alter it, and they take effect from the next frame.
- R4: When `busy_o` is low, a request sampled at clock edge k places the start bit on the enabled lanes in the cycle that follows edge k. `launch_o` is high for exactly that one cycle.
- R5: When both sources request at the same edge, the timing-controller word is sent and the host word is discarded.
- R6: A request made while a frame is running and the buffer is empty is held. Its frame begins in the cycle right after the last stop-bit cycle of the running frame.
- R7: A request made while the buffer already holds a word is discarded.
- R8: `busy_o` is high while a frame is running or a word is held, and it is low otherwise. While `busy_o` is low, all lanes are high.
- R9: `kind_o` is updated at each launch: 1 for 0xE311 (acquisition start), 2 for 0xE313 (acquisition stop), 3 for 0xE000 (clock alignment), 4 for 0x0000 (buffer reset), and 0 for any other word.
- R10: After reset, all lanes are high, `busy_o` and `launch_o` are low, and `kind_o` is 0.
- R11: The word 0x0000 is accepted and transmitted like any other word. Its frame is a start bit, sixteen low data bits and two stop bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 40 MHz system clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tc_valid_i | input | 1 | Timing-controller request strobe |
| tc_code_i | input | 16 | Timing-controller command word |
| host_valid_i | input | 1 | Host request strobe |
| host_code_i | input | 16 | Host command word |
| port_mask_i | input | NUM_PORTS | Per-lane enable mask |
| bit_period_i | input | PERIOD_W | Clock cycles per serial bit |
| port_line_o | output | NUM_PORTS | Serial command lanes, idle high |
| busy_o | output | 1 | Frame running or word held |
| launch_o | output | 1 | One-cycle pulse at the first start-bit cycle |
| kind_o | output | 3 | Class of the most recently launched word |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is a request from each source. The bench raises both strobes on one edge and then expects the timing-controller frame bit for bit, followed by silent lanes and a low `busy_o`. The second pair is the buffer draining while a new request arrives. The bench times a host request into the middle of a running frame, changes mask and period under it, and then expects the held word to start in the very next cycle after the last stop bit, using the new mask. A third request made while the buffer is full must leave no trace on the lanes.

// File: rtl/fcb_pkg.sv
package fcb_pkg;

    localparam int CMD_W     = 16;
    localparam int STOP_BITS = 2;
    localparam int FRAME_W   = 1 + CMD_W + STOP_BITS;
    localparam int BITCNT_W  = $clog2(FRAME_W);

    localparam logic [CMD_W-1:0] CODE_ACQ_START = 16'hE311;
    localparam logic [CMD_W-1:0] CODE_ACQ_STOP  = 16'hE313;
    localparam logic [CMD_W-1:0] CODE_ALIGN     = 16'hE000;
    localparam logic [CMD_W-1:0] CODE_BUF_RESET = 16'h0000;

    typedef enum logic [2:0] {
        KIND_OTHER     = 3'd0,
        KIND_ACQ_START = 3'd1,
        KIND_ACQ_STOP  = 3'd2,
        KIND_ALIGN     = 3'd3,
        KIND_BUF_RESET = 3'd4
    } cmd_kind_e;

    typedef struct packed {
        logic             valid;
        logic [CMD_W-1:0] code;
    } cmd_req_t;

    function automatic cmd_kind_e classify(input logic [CMD_W-1:0] code);
        case (code)
            CODE_ACQ_START: return KIND_ACQ_START;
            CODE_ACQ_STOP:  return KIND_ACQ_STOP;
            CODE_ALIGN:     return KIND_ALIGN;
            CODE_BUF_RESET: return KIND_BUF_RESET;
            default:        return KIND_OTHER;
        endcase
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(input logic [CMD_W-1:0] code);
        return {{STOP_BITS{1'b1}}, code, 1'b0};
    endfunction

endpackage

// File: rtl/fcb_req_arbiter.sv
module fcb_req_arbiter
    import fcb_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tc_valid_i,
    input  logic [CMD_W-1:0] tc_code_i,
    input  logic             host_valid_i,
    input  logic [CMD_W-1:0] host_code_i,
    input  logic             ready_i,
    output logic             launch_o,
    output logic [CMD_W-1:0] code_o,
    output logic             pend_o
);

    cmd_req_t sel;
    cmd_req_t pend_q;

    always_comb begin
        sel.valid = tc_valid_i | host_valid_i;
        sel.code  = tc_valid_i ? tc_code_i : host_code_i;
    end

    assign launch_o = ready_i & (pend_q.valid | sel.valid);
    assign code_o   = pend_q.valid ? pend_q.code : sel.code;
    assign pend_o   = pend_q.valid;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= '0;
        end else if (launch_o && pend_q.valid) begin
            pend_q <= sel;
        end else if (!launch_o && sel.valid && !pend_q.valid) begin
            pend_q <= sel;
        end
    end

endmodule

// File: rtl/fcb_frame_serializer.sv
module fcb_frame_serializer
    import fcb_pkg::*;
#(
    parameter int PERIOD_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                load_i,
    input  logic [CMD_W-1:0]    code_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                line_o,
    output logic                active_o,
    output logic                ready_o
);

    logic [FRAME_W-1:0]  shreg_q;
    logic [BITCNT_W-1:0] bit_cnt_q;
    logic [PERIOD_W-1:0] div_cnt_q;
    logic [PERIOD_W-1:0] period_q;
    logic                active_q;
    logic                bit_end;
    logic                last_tick;

    assign bit_end   = active_q && (div_cnt_q == period_q - 1'b1);
    assign last_tick = bit_end && (bit_cnt_q == BITCNT_W'(FRAME_W - 1));
    assign ready_o   = !active_q || last_tick;
    assign active_o  = active_q;
    assign line_o    = active_q ? shreg_q[0] : 1'b1;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shreg_q   <= '1;
            bit_cnt_q <= '0;
            div_cnt_q <= '0;
            period_q  <= PERIOD_W'(1);
            active_q  <= 1'b0;
        end else if (load_i) begin
            shreg_q   <= build_frame(code_i);
            bit_cnt_q <= '0;
            div_cnt_q <= '0;
            period_q  <= (period_i == '0) ? PERIOD_W'(1) : period_i;
            active_q  <= 1'b1;
        end else if (active_q) begin
            if (bit_end) begin
                div_cnt_q <= '0;
                shreg_q   <= {1'b1, shreg_q[FRAME_W-1:1]};
                if (last_tick) begin
                    active_q <= 1'b0;
                end else begin
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
            end else begin
                div_cnt_q <= div_cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fcb_port_fanout.sv
module fcb_port_fanout #(
    parameter int NUM_PORTS = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 load_i,
    input  logic [NUM_PORTS-1:0] mask_i,
    input  logic                 line_i,
    output logic [NUM_PORTS-1:0] port_o
);

    logic [NUM_PORTS-1:0] en_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q <= '0;
        end else if (load_i) begin
            en_q <= mask_i;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
        assign port_o[p] = en_q[p] ? line_i : 1'b1;
    end

endmodule

// File: rtl/fast_cmd_broadcast.sv
module fast_cmd_broadcast
    import fcb_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int PERIOD_W  = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 tc_valid_i,
    input  logic [15:0]          tc_code_i,
    input  logic                 host_valid_i,
    input  logic [15:0]          host_code_i,
    input  logic [NUM_PORTS-1:0] port_mask_i,
    input  logic [PERIOD_W-1:0]  bit_period_i,
    output logic [NUM_PORTS-1:0] port_line_o,
    output logic                 busy_o,
    output logic                 launch_o,
    output logic [2:0]           kind_o
);

    logic             ser_ready;
    logic             ser_active;
    logic             ser_line;
    logic             load;
    logic [CMD_W-1:0] load_code;
    logic             pend;
    logic             launch_q;
    cmd_kind_e        kind_q;

    fcb_req_arbiter u_arb (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .tc_valid_i   (tc_valid_i),
        .tc_code_i    (tc_code_i),
        .host_valid_i (host_valid_i),
        .host_code_i  (host_code_i),
        .ready_i      (ser_ready),
        .launch_o     (load),
        .code_o       (load_code),
        .pend_o       (pend)
    );

    fcb_frame_serializer #(.PERIOD_W(PERIOD_W)) u_ser (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (load),
        .code_i   (load_code),
        .period_i (bit_period_i),
        .line_o   (ser_line),
        .active_o (ser_active),
        .ready_o  (ser_ready)
    );

    fcb_port_fanout #(.NUM_PORTS(NUM_PORTS)) u_fan (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load),
        .mask_i (port_mask_i),
        .line_i (ser_line),
        .port_o (port_line_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            launch_q <= 1'b0;
            kind_q   <= KIND_OTHER;
        end else begin
            launch_q <= load;
            if (load) begin
                kind_q <= classify(load_code);
            end
        end
    end

    assign busy_o   = ser_active | pend;
    assign launch_o = launch_q;
    assign kind_o   = kind_q;

endmodule

// File: rtl/fast_cmd_broadcast_chk.sv
module fast_cmd_broadcast_chk #(
    parameter int NUM_PORTS = 8,
    parameter int PERIOD_W  = 8
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 tc_valid_i,
    input logic                 host_valid_i,
    input logic [NUM_PORTS-1:0] port_mask_i,
    input logic [NUM_PORTS-1:0] port_line_o,
    input logic                 busy_o,
    input logic                 launch_o
);

    // R2: at launch, exactly the lanes enabled at the launch edge show the start bit
    a_r2_start_on_mask: assert property (@(posedge clk_i) disable iff (rst_i)
        (launch_o && !$past(rst_i)) |-> ((~port_line_o) == $past(port_mask_i)));

    // R4: an idle transmitter answers a request on the next cycle
    a_r4_fixed_latency: assert property (@(posedge clk_i) disable iff (rst_i)
        ((tc_valid_i || host_valid_i) && !busy_o) |=> launch_o);

    // R4: the launch strobe lasts one cycle
    a_r4_launch_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        launch_o |=> !launch_o);

    // R8: a launch always shows busy
    a_r8_busy_at_launch: assert property (@(posedge clk_i) disable iff (rst_i)
        launch_o |-> busy_o);

    // R8: lanes idle high whenever not busy
    a_r8_idle_high: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> (&port_line_o));

endmodule

bind fast_cmd_broadcast fast_cmd_broadcast_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PERIOD_W  (PERIOD_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .tc_valid_i   (tc_valid_i),
    .host_valid_i (host_valid_i),
    .port_mask_i  (port_mask_i),
    .port_line_o  (port_line_o),
    .busy_o       (busy_o),
    .launch_o     (launch_o)
);

// File: tb/fast_cmd_broadcast_tb_top.sv
module fast_cmd_broadcast_tb_top;

    localparam int NP = 8;
    localparam int PW = 8;
    localparam int FW = 19;

    logic          clk = 1'b0;
    logic          rst;
    logic          tc_valid, host_valid;
    logic [15:0]   tc_code, host_code;
    logic [NP-1:0] mask;
    logic [PW-1:0] period;
    logic [NP-1:0] lines;
    logic          busy, launch;
    logic [2:0]    kind;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    fast_cmd_broadcast #(.NUM_PORTS(NP), .PERIOD_W(PW)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .tc_valid_i   (tc_valid),
        .tc_code_i    (tc_code),
        .host_valid_i (host_valid),
        .host_code_i  (host_code),
        .port_mask_i  (mask),
        .bit_period_i (period),
        .port_line_o  (lines),
        .busy_o       (busy),
        .launch_o     (launch),
        .kind_o       (kind)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Strobe a request for one edge; returns at the first sample point after it.
    task automatic request(input bit from_tc, input bit from_host, input logic [15:0] tcc, input logic [15:0] hc);
        tc_valid = from_tc; host_valid = from_host; tc_code = tcc; host_code = hc;
        @(negedge clk);
        tc_valid = 0; host_valid = 0;
    endtask

    // Called at the first cycle of a frame; compares every cycle, one check per bit.
    task automatic check_frame(input logic [15:0] code, input logic [NP-1:0] m, input int per,
                               input logic [2:0] kexp, input string req);
        logic eb;
        logic [NP-1:0] exp_l;
        logic [NP-1:0] bad_l;
        bit bad;
        chk(launch === 1'b1 && kind === kexp, {req, " R4 R9 launch/kind"}, {launch, kind}, {1'b1, kexp});
        for (int b = 0; b < FW; b++) begin
            eb = (b == 0) ? 1'b0 : (b <= 16) ? code[b-1] : 1'b1;
            exp_l = ~m | (eb ? m : '0);
            bad = 0; bad_l = '0;
            for (int c = 0; c < per; c++) begin
                if (b != 0 || c != 0) @(negedge clk);
                if (lines !== exp_l || busy !== 1'b1) begin bad = 1; bad_l = lines; end
            end
            chk(!bad, {req, " R1 R2 bit"}, {bad_l, 8'(b)}, {exp_l, 8'(b)});
        end
    endtask

    task automatic expect_idle(input int n, input string req);
        bit bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (lines !== '1 || busy !== 1'b0 || launch !== 1'b0) bad = 1;
        end
        chk(!bad, {req, " idle"}, {lines, busy, launch}, {8'hFF, 2'b00});
    endtask

    task automatic t_reset;
        chk(lines === '1 && busy === 0 && launch === 0 && kind === 3'd0, "R10 reset state",
            {lines, busy, launch, kind}, {8'hFF, 5'b00000});
    endtask

    task automatic t_tc_start;
        mask = 8'hA5; period = 8'd1;
        request(1, 0, 16'hE311, 16'h0);
        check_frame(16'hE311, 8'hA5, 1, 3'd1, "R1 R2 acq start");
        expect_idle(3, "R8 after start");
    endtask

    task automatic t_host_stop;
        mask = 8'hFF; period = 8'd3;
        request(0, 1, 16'h0, 16'hE313);
        check_frame(16'hE313, 8'hFF, 3, 3'd2, "R1 acq stop");
        expect_idle(2, "R8 after stop");
    endtask

    task automatic t_align_other;
        mask = 8'h3C; period = 8'd2;
        request(1, 0, 16'hE000, 16'h0);
        check_frame(16'hE000, 8'h3C, 2, 3'd3, "R4 align latency");
        expect_idle(1, "R8 after align");
        mask = 8'h01;
        request(0, 1, 16'h0, 16'h5A3C);
        check_frame(16'h5A3C, 8'h01, 2, 3'd0, "R9 other word");
        expect_idle(1, "R8 after other");
    endtask

    task automatic t_buf_reset;
        mask = 8'hF0; period = 8'd0;
        request(0, 1, 16'h0, 16'h0000);
        check_frame(16'h0000, 8'hF0, 1, 3'd4, "R11 zero word, period 0 as 1");
        expect_idle(2, "R8 after zero word");
    endtask

    task automatic t_collide;
        mask = 8'h0F; period = 8'd1;
        request(1, 1, 16'hE313, 16'h1234);
        check_frame(16'hE313, 8'h0F, 1, 3'd2, "R5 timing side wins");
        expect_idle(4, "R5 host word dropped");
    endtask

    task automatic t_pending;
        mask = 8'h81; period = 8'd2;
        request(1, 0, 16'hC0DE, 16'h0);
        fork
            check_frame(16'hC0DE, 8'h81, 2, 3'd0, "R3 frame A unaffected");
            begin
                repeat (5) @(negedge clk);
                mask = 8'h42; period = 8'd1;
                request(0, 1, 16'h0, 16'hE311);
                chk(busy === 1'b1, "R8 busy with held word", busy, 1);
            end
        join
        @(negedge clk);
        check_frame(16'hE311, 8'h42, 1, 3'd1, "R6 R3 held frame back to back");
        expect_idle(2, "R8 after held frame");
    endtask

    task automatic t_full;
        mask = 8'hFF; period = 8'd1;
        request(1, 0, 16'hAAAA, 16'h0);
        fork
            check_frame(16'hAAAA, 8'hFF, 1, 3'd0, "R7 frame A");
            begin
                repeat (3) @(negedge clk);
                request(0, 1, 16'h0, 16'h0F0F);
                repeat (2) @(negedge clk);
                request(1, 0, 16'hE000, 16'h0);
            end
        join
        @(negedge clk);
        check_frame(16'h0F0F, 8'hFF, 1, 3'd0, "R7 held word kept");
        expect_idle(4, "R7 third word dropped");
    endtask

    initial begin
        rst = 1; tc_valid = 0; host_valid = 0; tc_code = 0; host_code = 0;
        mask = 0; period = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_tc_start();
        t_host_stop();
        t_align_other();
        t_buf_reset();
        t_collide();
        t_pending();
        t_full();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule